// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Invalidation Protection

This block is a sixteen-entry translation buffer in which every entry compares itself against an incoming virtual address in the same cycle. Each entry holds a valid bit, a protection bit, a two-bit page size, a virtual page number and a real page number. On a match the block returns the real address: the page size decides how many upper address bits come from the entry, and the remaining bits pass through from the virtual address. Lookups enter on a valid/ready request channel. Results leave one cycle later on a valid/ready response channel. A response held by back-pressure stays stable, and no new lookup is accepted while the response is held.

Software loads entries through a write port. The write goes to the index held in an entry-select register. The block never picks a victim itself. Software preloads a next-victim register, and a lookup miss copies that value into the entry-select register, so the following write lands there. Two invalidation commands exist. The flash command clears every entry at once. The address command clears the entries that translate one address, or every entry when its all-flag is set. Both commands skip entries whose protection bit is set. Such an entry only goes invalid when an entry write stores a valid bit of zero.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, rs_valid is 0, lk_ready is 1, and both the entry-select and next-victim registers hold 0.
- R2: A lookup is accepted when lk_valid and lk_ready are both 1. Its result appears on the response port at the next clock edge and is computed from the entry contents before that edge. A valid entry hits when its virtual page number equals the lookup address on every bit the page size compares. On a miss, rs_hit, rs_multi, rs_index and rs_raddr are all 0.
- R3: Page size code 0, 1, 2 or 3 means 4 KB, 64 KB, 1 MB or 16 MB. Address bits [31:12], [31:16], [31:20] or [31:24] are compared and are also replaced by the matching bits of the real page number. All lower bits come from the virtual address.
- R4: When several entries hit, rs_index reports the lowest-numbered one, the address is translated through that entry, and rs_multi is 1. With exactly one hit, rs_multi is 0.
- R5: When wr_en is 1, the entry at the current entry-select index takes wr_valid_bit, wr_protect, wr_size, wr_vpn and wr_rpn in that cycle. Lookups see the new contents from the next cycle. Writing a valid bit of 0 invalidates the entry even when it is protected.
- R6: flash_inv clears the valid bit of every unprotected entry in one cycle and leaves every protected entry unchanged.
- R7: addr_inv clears exactly the unprotected entries that hit addr_inv_va under their own page size. With addr_inv_all also set, it clears every unprotected entry. Protected entries are never cleared by it.
- R8: An accepted lookup that misses loads the entry-select register from the next-victim register. A hit leaves the entry-select register alone. Both registers can be written directly, and a direct write of entry-select in the same cycle wins over the load from a miss.
- R9: While rs_valid is 1 and rs_ready is 0, lk_ready is 0 and every response field holds its value. rs_valid falls after the response is taken unless a new lookup is accepted in the same cycle.
- R10: When an entry write and an invalidation hit the same entry in one cycle, the entry takes the written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vaddr | input | 32 | Virtual address to translate |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Consumer takes the response |
| rs_hit | output | 1 | Some entry matched |
| rs_multi | output | 1 | More than one entry matched |
| rs_index | output | 4 | Index of the reporting entry |
| rs_raddr | output | 32 | Translated real address |
| wr_en | input | 1 | Write entry at entry-select index |
| wr_valid_bit | input | 1 | Valid bit to store |
| wr_protect | input | 1 | Protection bit to store |
| wr_size | input | 2 | Page size code to store |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_rpn | input | 20 | Real page number to store |
| sel_wr_en | input | 1 | Load entry-select register directly |
| sel_wr_data | input | 4 | Value for entry-select register |
| nv_wr_en | input | 1 | Load next-victim register |
| nv_wr_data | input | 4 | Value for next-victim register |
| sel_out | output | 4 | Current entry-select register |
| nv_out | output | 4 | Current next-victim register |
| flash_inv | input | 1 | Clear all unprotected entries |
| addr_inv | input | 1 | Clear unprotected entries matching addr_inv_va |
| addr_inv_all | input | 1 | Widen addr_inv to all unprotected entries |
| addr_inv_va | input | 32 | Address for address-based invalidation |

## Verification
The assertions assume that reset is low at the first clock edge and that every control input has a known level at each edge. Nothing else is assumed about the inputs. Any mix of writes, invalidations and lookups in one cycle is legal, and lk_vaddr may change while a lookup waits. The stimulus holds reset from time zero and changes inputs one nanosecond after each rising edge. It deliberately piles writes, both invalidation commands and direct select writes into the same cycles, and it holds rs_ready low for runs of cycles so that the back-pressure rules are exercised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Page size code stored per entry; order fixes the masked width.
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  // Extra page-number bits left out of the compare per size step.
  localparam int unsigned SZ_STEP = 4;

  function automatic int unsigned ign_bits(pgsz_e s);
    return SZ_STEP * int'(s);
  endfunction
endpackage

// File: rtl/xlat_match.sv
// Per-entry comparator: one mask, two independent address compares
// (lookup port and invalidation port) sharing it.
module xlat_match
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 20
) (
  input  logic             vld,
  input  pgsz_e            size,
  input  logic [VPN_W-1:0] vpn_e,
  input  logic [VPN_W-1:0] vpn_a,
  input  logic [VPN_W-1:0] vpn_b,
  output logic             hit_a,
  output logic             hit_b,
  output logic [VPN_W-1:0] mask
);
  always_comb begin
    for (int unsigned b = 0; b < VPN_W; b++) begin
      mask[b] = (b >= ign_bits(size));
    end
  end

  assign hit_a = vld && (((vpn_e ^ vpn_a) & mask) == '0);
  assign hit_b = vld && (((vpn_e ^ vpn_b) & mask) == '0);
endmodule

// File: rtl/xlat_pick.sv
// Lowest-index priority pick over the hit vector plus multi-hit detect.
module xlat_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic             multi,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |hits;
  assign multi = |(hits & (hits - N'(1)));
endmodule

// File: rtl/xlat_victim.sv
// Entry-select and next-victim registers; direct write beats miss load.
module xlat_victim #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_d,
  input  logic             nv_we,
  input  logic [IDX_W-1:0] nv_d,
  input  logic             miss_load,
  output logic [IDX_W-1:0] sel_q,
  output logic [IDX_W-1:0] nv_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      nv_q  <= '0;
    end else begin
      if (sel_we)         sel_q <= sel_d;
      else if (miss_load) sel_q <= nv_q;
      if (nv_we)          nv_q  <= nv_d;
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter  int unsigned N          = 16,
  parameter  int unsigned VA_W       = 32,
  parameter  int unsigned PAGE_SHIFT = 12,
  localparam int unsigned IDX_W      = $clog2(N),
  localparam int unsigned VPN_W      = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic             rs_hit,
  output logic             rs_multi,
  output logic [IDX_W-1:0] rs_index,
  output logic [VA_W-1:0]  rs_raddr,
  input  logic             wr_en,
  input  logic             wr_valid_bit,
  input  logic             wr_protect,
  input  logic [1:0]       wr_size,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_rpn,
  input  logic             sel_wr_en,
  input  logic [IDX_W-1:0] sel_wr_data,
  input  logic             nv_wr_en,
  input  logic [IDX_W-1:0] nv_wr_data,
  output logic [IDX_W-1:0] sel_out,
  output logic [IDX_W-1:0] nv_out,
  input  logic             flash_inv,
  input  logic             addr_inv,
  input  logic             addr_inv_all,
  input  logic [VA_W-1:0]  addr_inv_va
);
  // Entry storage
  logic             vld_e  [N];
  logic             prt_e  [N];
  pgsz_e            size_e [N];
  logic [VPN_W-1:0] vpn_e  [N];
  logic [VPN_W-1:0] rpn_e  [N];
  logic [VPN_W-1:0] mask_e [N];

  logic [N-1:0] vld_q, prt_q, lk_hit, inv_hit;

  logic [VPN_W-1:0] lk_vpn, inv_vpn;
  assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_SHIFT];
  assign inv_vpn = addr_inv_va[VA_W-1:PAGE_SHIFT];

  logic lk_fire;
  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic clr, wr_here;

    xlat_match #(.VPN_W(VPN_W)) u_match (
      .vld   (vld_e[g]),
      .size  (size_e[g]),
      .vpn_e (vpn_e[g]),
      .vpn_a (lk_vpn),
      .vpn_b (inv_vpn),
      .hit_a (lk_hit[g]),
      .hit_b (inv_hit[g]),
      .mask  (mask_e[g])
    );

    assign clr     = !prt_e[g] &&
                     (flash_inv || (addr_inv && (addr_inv_all || inv_hit[g])));
    assign wr_here = wr_en && (sel_out == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_e[g]  <= 1'b0;
        prt_e[g]  <= 1'b0;
        size_e[g] <= PG_4K;
        vpn_e[g]  <= '0;
        rpn_e[g]  <= '0;
      end else if (wr_here) begin
        vld_e[g]  <= wr_valid_bit;
        prt_e[g]  <= wr_protect;
        size_e[g] <= pgsz_e'(wr_size);
        vpn_e[g]  <= wr_vpn;
        rpn_e[g]  <= wr_rpn;
      end else if (clr) begin
        vld_e[g]  <= 1'b0;
      end
    end

    assign vld_q[g] = vld_e[g];
    assign prt_q[g] = prt_e[g];
  end

  // Hit resolution
  logic             pk_any, pk_multi;
  logic [IDX_W-1:0] pk_idx;

  xlat_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .hits  (lk_hit),
    .any   (pk_any),
    .multi (pk_multi),
    .idx   (pk_idx)
  );

  logic [VPN_W-1:0] ra_vpn;
  assign ra_vpn = (rpn_e[pk_idx] & mask_e[pk_idx]) | (lk_vpn & ~mask_e[pk_idx]);

  // Response register with back-pressure hold
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_multi <= 1'b0;
      rs_index <= '0;
      rs_raddr <= '0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= pk_any;
      rs_multi <= pk_multi;
      rs_index <= pk_any ? pk_idx : '0;
      rs_raddr <= pk_any ? {ra_vpn, lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  xlat_victim #(.IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_wr_en),
    .sel_d     (sel_wr_data),
    .nv_we     (nv_wr_en),
    .nv_d      (nv_wr_data),
    .miss_load (lk_fire && !pk_any),
    .sel_q     (sel_out),
    .nv_q      (nv_out)
  );
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned VA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic             rs_hit,
  input logic             rs_multi,
  input logic [IDX_W-1:0] rs_index,
  input logic [VA_W-1:0]  rs_raddr,
  input logic             wr_en,
  input logic             wr_valid_bit,
  input logic             sel_wr_en,
  input logic [IDX_W-1:0] sel_out,
  input logic [IDX_W-1:0] nv_out,
  input logic             flash_inv,
  input logic             addr_inv,
  input logic [N-1:0]     vld_q,
  input logic [N-1:0]     prt_q
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (vld_q == '0 && !rs_valid && sel_out == '0 && nv_out == '0));

  assert_multi_has_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_multi) |-> rs_hit);

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(sel_out)] == $past(wr_valid_bit));

  assert_miss_loads_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !sel_wr_en) |=> (rs_hit || sel_out == $past(nv_out)));

  assert_hit_keeps_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !sel_wr_en) |=> (!rs_hit || sel_out == $past(sel_out)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_hit) && $stable(rs_multi)
                                 && $stable(rs_index) && $stable(rs_raddr)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !lk_ready);

  for (genvar i = 0; i < N; i++) begin : g_ent
    assert_flash_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_inv && prt_q[i] && vld_q[i] && !(wr_en && sel_out == IDX_W'(i)))
      |=> vld_q[i]);

    assert_flash_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_inv && !prt_q[i] && !(wr_en && sel_out == IDX_W'(i)))
      |=> !vld_q[i]);

    assert_inv_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_inv && prt_q[i] && vld_q[i] && !(wr_en && sel_out == IDX_W'(i)))
      |=> vld_q[i]);
  end
endmodule

bind xlat_buffer xlat_buffer_chk #(.N(N), .IDX_W(IDX_W), .VA_W(VA_W)) u_chk (.*);

// File: tb/tb_xlat_buffer.sv
module tb_xlat_buffer;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_ready, rs_valid, rs_ready, rs_hit, rs_multi;
  logic [31:0] lk_vaddr, rs_raddr, addr_inv_va;
  logic [3:0]  rs_index, sel_wr_data, nv_wr_data, sel_out, nv_out;
  logic        wr_en, wr_valid_bit, wr_protect, sel_wr_en, nv_wr_en;
  logic [1:0]  wr_size;
  logic [19:0] wr_vpn, wr_rpn;
  logic        flash_inv, addr_inv, addr_inv_all;

  always #2 clk = ~clk;

  xlat_buffer dut (.*);

  int    tests = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit          mv [N];
  bit          mp [N];
  int          ms [N];
  logic [19:0] mvp[N];
  logic [19:0] mrp[N];
  logic [3:0]  msel, mnv;
  bit          m_rsv, m_hit, m_multi;
  logic [3:0]  m_idx;
  logic [31:0] m_ra;
  logic [31:0] recent[8];

  function automatic bit covers(int i, logic [31:0] va);
    int sh = 12 + 4 * ms[i];
    return mv[i] && (({mvp[i], 12'h000} >> sh) == (va >> sh));
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vaddr = 0; rs_ready = 1;
    wr_en = 0; wr_valid_bit = 0; wr_protect = 0; wr_size = 0; wr_vpn = 0; wr_rpn = 0;
    sel_wr_en = 0; sel_wr_data = 0; nv_wr_en = 0; nv_wr_data = 0;
    flash_inv = 0; addr_inv = 0; addr_inv_all = 0; addr_inv_va = 0;
  endtask

  // Advance model by one clock from the current inputs, then compare.
  task automatic cycle();
    bit fire = lk_valid && (!m_rsv || rs_ready);
    int first = -1, cnt = 0;
    logic [3:0] wsel = msel;
    for (int i = 0; i < N; i++) begin
      if (covers(i, lk_vaddr)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    if (fire) begin
      m_rsv = 1; m_hit = (cnt > 0); m_multi = (cnt > 1);
      m_idx = (cnt > 0) ? 4'(first) : 4'd0;
      if (cnt > 0) begin
        int sh = 12 + 4 * ms[first];
        logic [31:0] lo = (32'd1 << sh) - 1;
        m_ra = ({mrp[first], 12'h000} & ~lo) | (lk_vaddr & lo);
      end else m_ra = 0;
    end else if (rs_ready) m_rsv = 0;
    for (int i = 0; i < N; i++) begin
      if (!mp[i] && (flash_inv || (addr_inv && (addr_inv_all || covers(i, addr_inv_va)))))
        mv[i] = 0;
    end
    if (wr_en) begin
      mv[wsel] = wr_valid_bit; mp[wsel] = wr_protect; ms[wsel] = int'(wr_size);
      mvp[wsel] = wr_vpn; mrp[wsel] = wr_rpn;
    end
    if (sel_wr_en) msel = sel_wr_data;
    else if (fire && cnt == 0) msel = mnv;
    if (nv_wr_en) mnv = nv_wr_data;
    @(posedge clk); #1;
    chk("rs_valid", 32'(rs_valid), 32'(m_rsv));
    chk("lk_ready", 32'(lk_ready), 32'(!m_rsv || rs_ready));
    chk("sel_out", 32'(sel_out), 32'(msel));
    chk("nv_out", 32'(nv_out), 32'(mnv));
    if (m_rsv) begin
      chk("rs_hit", 32'(rs_hit), 32'(m_hit));
      chk("rs_multi", 32'(rs_multi), 32'(m_multi));
      chk("rs_index", 32'(rs_index), 32'(m_idx));
      chk("rs_raddr", rs_raddr, m_ra);
    end
  endtask

  task automatic write_entry(input int idx, input bit v, input bit p, input int sz,
                             input logic [31:0] va, input logic [31:0] ra);
    sel_wr_en = 1; sel_wr_data = 4'(idx); cycle(); sel_wr_en = 0;
    wr_en = 1; wr_valid_bit = v; wr_protect = p; wr_size = 2'(sz);
    wr_vpn = va[31:12]; wr_rpn = ra[31:12]; cycle(); wr_en = 0;
  endtask

  task automatic lookup(input logic [31:0] va);
    lk_valid = 1; lk_vaddr = va; cycle(); lk_valid = 0; cycle();
  endtask

  function automatic logic [31:0] rva();
    logic [31:0] v = $urandom;
    return v & 32'h3011_3fff;
  endfunction

  initial begin
    idle();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mp[i] = 0; ms[i] = 0; mvp[i] = 0; mrp[i] = 0;
    end
    msel = 0; mnv = 0; m_rsv = 0; m_hit = 0; m_multi = 0; m_idx = 0; m_ra = 0;
    for (int k = 0; k < 8; k++) recent[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    cur_req = "R1"; cycle(); lookup(32'h0000_0000); lookup(32'h1234_5678);

    cur_req = "R3";
    write_entry(0, 1, 0, 0, 32'h1000_1000, 32'hA000_0000);
    write_entry(1, 1, 0, 1, 32'h2001_0000, 32'hB123_4000);
    write_entry(2, 1, 0, 2, 32'h3010_0000, 32'hC345_6000);
    write_entry(3, 1, 0, 3, 32'h4100_0000, 32'hD567_8000);
    lookup(32'h1000_1abc); lookup(32'h1000_2abc);
    lookup(32'h2001_f123); lookup(32'h301f_e456);
    lookup(32'h41ff_f789); lookup(32'h4200_0000);

    cur_req = "R5"; write_entry(7, 1, 0, 0, 32'h5000_0000, 32'h6000_0000);
    lk_valid = 1; lk_vaddr = 32'h5000_0010; cycle(); lk_valid = 0; cycle();

    cur_req = "R4";
    write_entry(9, 1, 0, 1, 32'h4101_0000, 32'hE000_0000);
    write_entry(5, 1, 0, 0, 32'h4101_0000, 32'hF000_0000);
    lookup(32'h4101_0044); lookup(32'h4101_8044);

    cur_req = "R6";
    write_entry(2, 1, 1, 2, 32'h3010_0000, 32'hC345_6000);
    flash_inv = 1; cycle(); flash_inv = 0;
    for (int k = 0; k < 4; k++) lookup(32'h1000_1000 * (k + 1) + 32'h0010_0000 * (k / 2));
    lookup(32'h3010_0000); lookup(32'h4101_0044);

    cur_req = "R7";
    write_entry(0, 1, 0, 0, 32'h1000_1000, 32'hA000_0000);
    write_entry(1, 1, 0, 1, 32'h2001_0000, 32'hB123_4000);
    write_entry(4, 1, 1, 1, 32'h2001_0000, 32'h9000_0000);
    addr_inv = 1; addr_inv_va = 32'h2001_5555; cycle(); addr_inv = 0;
    lookup(32'h2001_0000); lookup(32'h1000_1000);
    addr_inv = 1; addr_inv_all = 1; addr_inv_va = 32'h7777_7000; cycle();
    addr_inv = 0; addr_inv_all = 0;
    lookup(32'h1000_1000); lookup(32'h3010_0000); lookup(32'h2001_0000);

    cur_req = "R5"; write_entry(2, 0, 1, 2, 32'h3010_0000, 32'hC345_6000);
    lookup(32'h3010_0000);

    cur_req = "R8";
    nv_wr_en = 1; nv_wr_data = 4'd11; cycle(); nv_wr_en = 0;
    lookup(32'h0bad_0000); lookup(32'h2001_0000);
    nv_wr_en = 1; nv_wr_data = 4'd6; cycle(); nv_wr_en = 0;
    lk_valid = 1; lk_vaddr = 32'h0bad_0000; sel_wr_en = 1; sel_wr_data = 4'd3; cycle();
    lk_valid = 0; sel_wr_en = 0; cycle();

    cur_req = "R9";
    rs_ready = 0; lk_valid = 1; lk_vaddr = 32'h2001_0000; cycle();
    lk_vaddr = 32'h0bad_0000; repeat (4) cycle();
    rs_ready = 1; cycle(); lk_valid = 0; cycle(); cycle();

    cur_req = "R10";
    sel_wr_en = 1; sel_wr_data = 4'd0; cycle(); sel_wr_en = 0;
    wr_en = 1; wr_valid_bit = 1; wr_protect = 0; wr_size = 0; wr_vpn = 20'h5555_5;
    wr_rpn = 20'h1111_1; flash_inv = 1; lk_valid = 1; lk_vaddr = 32'h5555_5000; cycle();
    wr_en = 0; flash_inv = 0; cycle(); lk_valid = 0; cycle();

    cur_req = "R2";
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] a = rva();
      idle();
      lk_valid = ($urandom_range(0, 9) < 6);
      lk_vaddr = ($urandom_range(0, 1) != 0) ? (recent[$urandom_range(0, 7)] | (a & 32'h0000_0fff)) : a;
      rs_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 9) < 2) begin
        wr_en = 1; wr_valid_bit = ($urandom_range(0, 7) != 0);
        wr_protect = ($urandom_range(0, 9) < 3); wr_size = 2'($urandom_range(0, 3));
        wr_vpn = a[31:12]; wr_rpn = 20'($urandom);
        recent[c % 8] = a;
      end
      if ($urandom_range(0, 9) < 2) begin sel_wr_en = 1; sel_wr_data = 4'($urandom); end
      if ($urandom_range(0, 9) < 1) begin nv_wr_en = 1; nv_wr_data = 4'($urandom); end
      if ($urandom_range(0, 49) == 0) flash_inv = 1;
      if ($urandom_range(0, 19) == 0) begin
        addr_inv = 1; addr_inv_va = recent[$urandom_range(0, 7)];
        addr_inv_all = ($urandom_range(0, 4) == 0);
      end
      cycle();
    end
    idle(); cycle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog %s: actual hung expected finished", cur_req);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule